// File: doc/BRIEF.md
# DMA Channel Control and Status Registers

This block holds the software-visible state of a single DMA channel. A processor reaches it through a simple 32-bit register port that decodes a 16-byte window into four word registers: a control/status word, the current memory address, a byte count and one spare general-purpose word. The block keeps the direction, interrupt-enable and "address loaded" flags. It turns the attached peripheral's interrupt level into a status flag and gates that flag onto the processor interrupt line. It can also issue a reset pulse to the peripheral.

The transfer datapath reports each finished burst with a one-cycle strobe and a byte length. The block then advances the current address by that length and raises the status flag. Reads return stored values with no side effects. Several control bits act as commands when written: the drain command never stays set in the stored value, and the reset command produces a single-cycle pulse.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset the control word reads 0xA000_0000 and the address, count and spare words read 0. `cpu_irq` and `periph_rst` are low.
- R2: Bits [3:2] of `reg_addr` select the word: 0 is control, 1 is address, 2 is count and 3 is spare. Bits [1:0] are ignored. Reads are combinational and change no state.
- R3: A write to the control word stores the written value, except that bit 6 (drain command) is stored as 0 and bit 0 (interrupt status) keeps its hardware-maintained value.
- R4: Bit 4 of the control word is the interrupt enable. In the cycle after a control write with bit 4 clear, `cpu_irq` is low.
- R5: A control write with bit 7 set drives `periph_rst` high for exactly the one cycle after the write edge. `periph_rst` is never high at any other time.
- R6: A write to the address word stores the value and sets bit 26 (loaded flag) of the control word.
- R7: A rising edge of `periph_irq` sets control bit 0, and a falling edge clears it. `cpu_irq` is high exactly when bit 0 and bit 4 are both set.
- R8: A `xfer_done` strobe sets control bit 0 and adds the zero-extended `xfer_len` to the address word, modulo 2^32.
- R9: An address write in the same cycle as `xfer_done` wins over the increment. A set from a rising edge or from `xfer_done` wins over a clear from a falling edge in the same cycle.
- R10: Writes to the count and spare words store the value unchanged.
- R11: `dir_to_mem` follows control bit 8 (1 means the peripheral writes memory).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Byte address within the window |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| periph_irq | input | 1 | Peripheral interrupt level |
| xfer_done | input | 1 | One-cycle transfer completion strobe |
| xfer_len | input | LEN_W | Bytes moved by the completed transfer |
| cpu_irq | output | 1 | Interrupt to the processor |
| periph_rst | output | 1 | One-cycle reset pulse to the peripheral |
| dir_to_mem | output | 1 | Transfer direction flag |

## Verification
The bench goes after these corner cases: an address write in the same cycle as a completion strobe, where a wrong design would add the length to the new address; a falling peripheral interrupt together with a completion, where a design would lose the status flag; and an address increment that wraps past 2^32. It also checks that a drain command written together with other bits leaves bit 6 at zero, and that a reset command pulses once and does not stay high. It checks that a control write clearing the enable drops `cpu_irq` even while the status flag stays set, and that low address bits alias onto the same word instead of decoding to a different one.

// File: rtl/dma_chan_regs.sv
module dma_chan_regs #(
  parameter int          LEN_W      = 24,
  parameter logic [31:0] RESET_CTRL = 32'hA000_0000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [3:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             periph_irq,
  input  logic             xfer_done,
  input  logic [LEN_W-1:0] xfer_len,
  output logic             cpu_irq,
  output logic             periph_rst,
  output logic             dir_to_mem
);
  localparam int STAT_B  = 0;
  localparam int IEN_B   = 4;
  localparam int DRAIN_B = 6;
  localparam int PRST_B  = 7;
  localparam int DIR_B   = 8;
  localparam int LOAD_B  = 26;

  logic [31:0] ctrl_q, addr_q, count_q, spare_q;
  logic        irq_prev_q, prst_q;
  logic        stat_d;

  wire [1:0] idx     = reg_addr[3:2];
  wire       wr_ctrl = reg_wr && idx == 2'd0;
  wire       wr_addr = reg_wr && idx == 2'd1;
  wire       wr_cnt  = reg_wr && idx == 2'd2;
  wire       wr_spr  = reg_wr && idx == 2'd3;
  wire       irq_up  = periph_irq && !irq_prev_q;
  wire       irq_dn  = !periph_irq && irq_prev_q;

  always_comb begin
    stat_d = ctrl_q[STAT_B];
    if (irq_dn) stat_d = 1'b0;
    if (irq_up || xfer_done) stat_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q     <= RESET_CTRL;
      addr_q     <= '0;
      count_q    <= '0;
      spare_q    <= '0;
      irq_prev_q <= 1'b0;
      prst_q     <= 1'b0;
    end else begin
      irq_prev_q <= periph_irq;
      prst_q     <= wr_ctrl && reg_wdata[PRST_B];
      if (wr_ctrl) begin
        ctrl_q          <= reg_wdata;
        ctrl_q[DRAIN_B] <= 1'b0;
      end
      ctrl_q[STAT_B] <= stat_d;
      if (wr_addr) begin
        addr_q         <= reg_wdata;
        ctrl_q[LOAD_B] <= 1'b1;
      end else if (xfer_done) begin
        addr_q <= addr_q + 32'(xfer_len);
      end
      if (wr_cnt) count_q <= reg_wdata;
      if (wr_spr) spare_q <= reg_wdata;
    end
  end

  always_comb begin
    case (idx)
      2'd0:    reg_rdata = ctrl_q;
      2'd1:    reg_rdata = addr_q;
      2'd2:    reg_rdata = count_q;
      default: reg_rdata = spare_q;
    endcase
  end

  assign cpu_irq    = ctrl_q[STAT_B] & ctrl_q[IEN_B];
  assign periph_rst = prst_q;
  assign dir_to_mem = ctrl_q[DIR_B];
endmodule

module dma_chan_regs_chk #(
  parameter int LEN_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic [3:0]       reg_addr,
  input logic [31:0]      reg_wdata,
  input logic             periph_irq,
  input logic             xfer_done,
  input logic [LEN_W-1:0] xfer_len,
  input logic             cpu_irq,
  input logic             periph_rst,
  input logic [31:0]      ctrl_q,
  input logic [31:0]      addr_q,
  input logic             irq_prev_q
);
  wire wc = reg_wr && reg_addr[3:2] == 2'd0;
  wire wa = reg_wr && reg_addr[3:2] == 2'd1;

  assert_drain_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wc |=> !ctrl_q[6]);
  assert_ien_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wc && !reg_wdata[4]) |=> !cpu_irq);
  assert_pulse_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    periph_rst |=> !periph_rst);
  assert_pulse_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wc && reg_wdata[7]) |=> periph_rst);
  assert_loaded_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wa |=> (ctrl_q[26] && addr_q == $past(reg_wdata)));
  assert_irq_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (periph_irq && !irq_prev_q) |=> ctrl_q[0]);
  assert_addr_adv_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && !wa) |=> (ctrl_q[0] && addr_q == $past(addr_q) + 32'($past(xfer_len))));
endmodule

bind dma_chan_regs dma_chan_regs_chk #(.LEN_W(LEN_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .periph_irq(periph_irq), .xfer_done(xfer_done),
  .xfer_len(xfer_len), .cpu_irq(cpu_irq), .periph_rst(periph_rst),
  .ctrl_q(ctrl_q), .addr_q(addr_q), .irq_prev_q(irq_prev_q)
);

// File: tb/test_dma_chan_regs.sv
`timescale 1ns/1ps
module test_dma_chan_regs;
  logic        clk = 0, rst_n = 0;
  logic        reg_wr = 0;
  logic [3:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic        periph_irq = 0, xfer_done = 0;
  logic [23:0] xfer_len = 0;
  logic        cpu_irq, periph_rst, dir_to_mem;
  int n_cmp = 0, n_bad = 0;

  always #4 clk = ~clk;

  dma_chan_regs i_dma_chan_regs (.*);

  // behavioural reference
  logic [31:0] m_reg [4];
  logic m_prev, m_pulse;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_reg[0] = 32'hA000_0000; m_reg[1] = 0; m_reg[2] = 0; m_reg[3] = 0;
      m_prev = 0; m_pulse = 0;
    end else begin
      bit st;
      int k;
      k = int'(reg_addr) / 4;
      st = m_reg[0][0];
      if (!periph_irq && m_prev) st = 0;
      if ((periph_irq && !m_prev) || xfer_done) st = 1;
      m_pulse = reg_wr && k == 0 && reg_wdata[7];
      if (reg_wr && k == 0) m_reg[0] = reg_wdata & ~32'h40;
      m_reg[0][0] = st;
      if (reg_wr && k == 1) begin
        m_reg[1] = reg_wdata; m_reg[0][26] = 1;
      end else if (xfer_done) m_reg[1] = m_reg[1] + {8'h0, xfer_len};
      if (reg_wr && k == 2) m_reg[2] = reg_wdata;
      if (reg_wr && k == 3) m_reg[3] = reg_wdata;
      m_prev = periph_irq;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      check("R2 rdata", reg_rdata, m_reg[int'(reg_addr) / 4]);
      check("R7 cpu_irq", 32'(cpu_irq), 32'(m_reg[0][0] & m_reg[0][4]));
      check("R5 periph_rst", 32'(periph_rst), 32'(m_pulse));
      check("R11 dir", 32'(dir_to_mem), 32'(m_reg[0][8]));
    end
  end

  task automatic wr(int k, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = 4'(k * 4); reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(logic [3:0] a, logic [31:0] exp, string req);
    reg_addr = a; #0.5;
    check(req, reg_rdata, exp);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset values
    rd(4'h0, 32'hA000_0000, "R1 ctrl");
    rd(4'h4, 0, "R1 addr");
    rd(4'h8, 0, "R1 count");
    rd(4'hC, 0, "R1 spare");
    check("R1 cpu_irq", 32'(cpu_irq), 0);
    check("R1 periph_rst", 32'(periph_rst), 0);
    // R10 count and spare
    wr(2, 32'hDEAD_BEEF); rd(4'h8, 32'hDEAD_BEEF, "R10 count");
    wr(3, 32'h1234_5678); rd(4'hF, 32'h1234_5678, "R10 spare R2 alias");
    // R6 loaded flag and R2 alias
    wr(1, 32'h0000_1000);
    rd(4'h5, 32'h0000_1000, "R2 alias addr");
    rd(4'h0, 32'hA400_0000, "R6 loaded");
    // R3 drain cleared, R11 dir
    wr(0, 32'h0000_0150);
    rd(4'h0, 32'h0000_0110, "R3 drain");
    check("R11 dir", 32'(dir_to_mem), 1);
    // R7 irq rise and fall
    @(negedge clk); periph_irq = 1;
    @(negedge clk); @(negedge clk);
    check("R7 irq high", 32'(cpu_irq), 1);
    // R4 enable clear
    wr(0, 32'h0000_0000);
    check("R4 irq dropped", 32'(cpu_irq), 0);
    rd(4'h0, 32'h0000_0001, "R3 status kept");
    periph_irq = 0;
    @(negedge clk);
    rd(4'h0, 32'h0, "R7 fall clears");
    // R5 reset pulse
    @(negedge clk); reg_wr = 1; reg_addr = 0; reg_wdata = 32'h0000_0090;
    @(posedge clk); #2;
    check("R5 pulse high", 32'(periph_rst), 1);
    @(negedge clk); reg_wr = 0;
    @(posedge clk); #2;
    check("R5 pulse low", 32'(periph_rst), 0);
    // R8 completion and wrap
    wr(1, 32'hFFFF_FFF0);
    @(negedge clk); xfer_done = 1; xfer_len = 24'h20;
    @(negedge clk); xfer_done = 0;
    rd(4'h4, 32'h0000_0010, "R8 wrap");
    rd(4'h0, 32'h0400_0091, "R8 status");
    // R9 write beats increment
    @(negedge clk); periph_irq = 1;
    @(negedge clk);
    reg_wr = 1; reg_addr = 4; reg_wdata = 32'h0000_4000;
    xfer_done = 1; xfer_len = 24'h100; periph_irq = 0;
    @(negedge clk); reg_wr = 0; xfer_done = 0;
    rd(4'h4, 32'h0000_4000, "R9 write wins");
    rd(4'h0, 32'h0400_0091, "R9 set beats clear");
    // varied pattern
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      reg_wr = (i % 3 == 0); reg_addr = 4'(i * 7);
      reg_wdata = 32'(i) * 32'h0101_1357;
      periph_irq = (i % 5 < 2); xfer_done = (i % 4 == 1); xfer_len = 24'(i * 33);
    end
    @(negedge clk); reg_wr = 0; xfer_done = 0;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule